// File: doc/BRIEF.md
# Bus-Attached Add/Subtract Unit

This unit hangs off a shared 16-bit data bus that many units drive in turn. It keeps a private pair of operand registers, A and B. Each register captures the bus word on a clock edge when its global strobe is high. The same two strobes go to every unit on the bus, so one bus transfer can load the A operand (or the B operand) of all units at once.

From the two operands the unit continuously forms the two's-complement sum A+B and the difference A-B. The control logic puts a 5-bit source address on the bus. When that address falls in the four-entry window assigned to this unit, the unit drives one of four values onto the bus: the sum, the difference, raw A or raw B. It also raises its output enable, which the chip level uses to gate a tri-state driver. Any other address leaves the enable low.

A carry flag and a zero flag are sent to the status-word unit so that later instructions can be skipped on a condition. The flags follow the difference while the subtract address is selected, and follow the sum at every other address.

Top module: `bus_adder`

## Requirements
- R1: While `rst_n` is low, A and B are cleared to zero, so reading A or B returns 0x0000.
- R2: On a rising clock edge with `latch_a` high, A takes the value of `bus_in`. With `latch_a` low, A keeps its value whatever the bus carries.
- R3: On a rising clock edge with `latch_b` high, B takes the value of `bus_in`. With `latch_b` low, B keeps its value. If both strobes are high, both registers take the same word.
- R4: When `src_addr` equals BASE+0, `bus_oe` is 1 and `bus_out` is (A+B) mod 2^16.
- R5: When `src_addr` equals BASE+1, `bus_oe` is 1 and `bus_out` is (A-B) mod 2^16, formed as A + ~B + 1.
- R6: When `src_addr` equals BASE+2, `bus_out` is A. When it equals BASE+3, `bus_out` is B. In both cases `bus_oe` is 1.
- R7: For any `src_addr` outside BASE..BASE+3, `bus_oe` is 0, so the unit never drives the bus at the same time as another source.
- R8: While `src_addr` equals BASE+1, `carry` is the raw carry out of A + ~B + 1, which is 1 exactly when A >= B unsigned (no borrow). At every other address `carry` is the carry out of A+B.
- R9: `zero` is 1 exactly when the result that `carry` refers to (the difference at BASE+1, the sum otherwise) is 0x0000.
- R10: `bus_out`, `bus_oe`, `carry` and `zero` follow a change of `src_addr` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 16 | Word currently on the shared bus |
| latch_a | input | 1 | Global strobe that loads A from the bus |
| latch_b | input | 1 | Global strobe that loads B from the bus |
| src_addr | input | 5 | Bus source address |
| bus_out | output | 16 | Value for the bus driver |
| bus_oe | output | 1 | Bus driver enable |
| carry | output | 1 | Carry out to the status word |
| zero | output | 1 | Zero result to the status word |

## Verification
The operand pairs are chosen to separate cases that a faulty adder would mix up: equal operands, which give a zero difference with carry set; A below B, which gives a borrow and a wrapped difference; all-ones plus one, which gives a zero sum with carry set; two values with the top bit set, which overflow; and ordinary values with no carry. Each pair is read at every address from one below the window to one above it, so a decoder off by one either enables on a neighbour address or leaves a hole in the window. The bench also loads both strobes at once, drives the bus without any strobe to show that the operands hold, and changes the address in the middle of a cycle to show that the output path is combinational.

// File: rtl/bus_adder.sv
module bus_adder #(
  parameter int W    = 16,
  parameter int AW   = 5,
  parameter int BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  bus_in,
  input  logic          latch_a,
  input  logic          latch_b,
  input  logic [AW-1:0] src_addr,
  output logic [W-1:0]  bus_out,
  output logic          bus_oe,
  output logic          carry,
  output logic          zero
);
  localparam logic [AW-1:0] ADDR_LO = AW'(BASE);
  localparam logic [AW-1:0] WIN     = AW'(4);

  logic [W-1:0]  a_q, b_q;
  logic [AW-1:0] off;
  logic          hit, is_sub;
  logic [W:0]    sum_x, diff_x;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (latch_a) a_q <= bus_in;
      if (latch_b) b_q <= bus_in;
    end

  assign sum_x  = {1'b0, a_q} + {1'b0, b_q};
  assign diff_x = {1'b0, a_q} + {1'b0, ~b_q} + (W+1)'(1);

  assign off    = src_addr - ADDR_LO;
  assign hit    = off < WIN;
  assign is_sub = hit && off[1:0] == 2'd1;

  always_comb begin
    bus_out = '0;
    if (hit)
      case (off[1:0])
        2'd0:    bus_out = sum_x[W-1:0];
        2'd1:    bus_out = diff_x[W-1:0];
        2'd2:    bus_out = a_q;
        default: bus_out = b_q;
      endcase
  end

  assign bus_oe = hit;
  assign carry  = is_sub ? diff_x[W] : sum_x[W];
  assign zero   = is_sub ? (diff_x[W-1:0] == '0) : (sum_x[W-1:0] == '0);
endmodule

module bus_adder_chk #(
  parameter int W    = 16,
  parameter int AW   = 5,
  parameter int BASE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  bus_in,
  input logic          latch_a,
  input logic          latch_b,
  input logic [AW-1:0] src_addr,
  input logic [W-1:0]  bus_out,
  input logic          bus_oe,
  input logic          carry,
  input logic          zero,
  input logic [W-1:0]  a_q,
  input logic [W-1:0]  b_q
);
  localparam logic [AW-1:0] A_ADD = AW'(BASE);
  localparam logic [AW-1:0] A_SUB = AW'(BASE + 1);
  localparam logic [AW-1:0] A_RDA = AW'(BASE + 2);
  localparam logic [AW-1:0] A_RDB = AW'(BASE + 3);

  p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_a |=> a_q == $past(bus_in));
  p_hold_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_a |=> $stable(a_q));
  p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_b |=> b_q == $past(bus_in));
  p_hold_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_b |=> $stable(b_q));
  p_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_ADD |-> bus_oe && bus_out == W'(a_q + b_q));
  p_diff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_SUB |-> bus_oe && bus_out == W'(a_q - b_q));
  p_raw_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_RDA |-> bus_oe && bus_out == a_q);
  p_raw_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_RDB |-> bus_oe && bus_out == b_q);
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_addr < A_ADD || src_addr > A_RDB) |-> !bus_oe);
  p_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_SUB |-> carry == (a_q >= b_q));
  p_zero_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_addr == A_SUB |-> zero == (a_q == b_q));
endmodule

bind bus_adder bus_adder_chk #(.W(W), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .latch_a(latch_a),
  .latch_b(latch_b), .src_addr(src_addr), .bus_out(bus_out),
  .bus_oe(bus_oe), .carry(carry), .zero(zero), .a_q(a_q), .b_q(b_q)
);

// File: tb/bus_adder_bench.sv
module bus_adder_bench;
  localparam int BASE = 8;
  localparam logic [4:0] IDLE = 5'd31;

  logic        clk = 0, rst_n = 0;
  logic        latch_a = 0, latch_b = 0;
  logic [4:0]  src_addr = IDLE;
  logic [15:0] tb_drv = '0;
  logic        tb_en = 0;
  logic [15:0] dut_out;
  logic        dut_oe, carry, zero;
  tri   [15:0] bus;

  assign bus = tb_en  ? tb_drv  : 'z;
  assign bus = dut_oe ? dut_out : 'z;

  bus_adder #(.W(16), .AW(5), .BASE(BASE)) u_bus_adder (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .latch_a(latch_a),
    .latch_b(latch_b), .src_addr(src_addr), .bus_out(dut_out),
    .bus_oe(dut_oe), .carry(carry), .zero(zero));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int m_a = 0, m_b = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin m_a = 0; m_b = 0; end
    else begin
      if (latch_a) m_a = tb_drv;
      if (latch_b) m_b = tb_drv;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, src_addr, act, exp);
    end
  endtask

  task automatic compare();
    int off, s, d, e_val, e_c, e_z;
    bit e_oe;
    off = int'(src_addr) - BASE;
    s = m_a + m_b;
    d = m_a + (m_b ^ 16'hffff) + 1;
    e_oe = off >= 0 && off < 4;
    case (off)
      0: e_val = s & 16'hffff;
      1: e_val = d & 16'hffff;
      2: e_val = m_a;
      3: e_val = m_b;
      default: e_val = 0;
    endcase
    if (off == 1) begin e_c = (d >> 16) & 1; e_z = (d & 16'hffff) == 0; end
    else          begin e_c = (s >> 16) & 1; e_z = (s & 16'hffff) == 0; end
    chk("R7 oe", int'(dut_oe), int'(e_oe));
    if (e_oe) begin
      case (off)
        0: chk("R4 sum", int'(dut_out), e_val);
        1: chk("R5 diff", int'(dut_out), e_val);
        2: chk("R2,R6 raw A", int'(dut_out), e_val);
        default: chk("R3,R6 raw B", int'(dut_out), e_val);
      endcase
      chk("R7 bus value", int'(bus), e_val);
    end
    chk("R8 carry", int'(carry), e_c);
    chk("R9 zero", int'(zero), e_z);
    if (tb_en) chk("R7 single driver", int'(dut_oe), 0);
  endtask

  always @(negedge clk) if (rst_n && !finished) compare();

  task automatic load(bit la, bit lb, logic [15:0] v);
    @(posedge clk); #1;
    src_addr = IDLE; tb_drv = v; tb_en = 1; latch_a = la; latch_b = lb;
    @(posedge clk); #1;
    tb_en = 0; latch_a = 0; latch_b = 0;
  endtask

  task automatic sweep();
    for (int k = BASE - 1; k <= BASE + 4; k++) begin
      @(posedge clk); #1;
      src_addr = 5'(k);
    end
    @(posedge clk); #1;
    src_addr = IDLE;
  endtask

  task automatic pair(logic [15:0] a, logic [15:0] b);
    load(1, 0, a);
    load(0, 1, b);
    sweep();
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; src_addr = 5'(BASE + 2);
    #1 chk("R1 reset A", int'(dut_out), 0);
    src_addr = 5'(BASE + 3);
    #1 chk("R1 reset B", int'(dut_out), 0);
    src_addr = IDLE;
    @(negedge clk); rst_n = 1;

    pair(16'h0000, 16'h0000);
    pair(16'h0001, 16'h0001);
    pair(16'hffff, 16'h0001);
    pair(16'h8000, 16'h8000);
    pair(16'h1234, 16'h1234);
    pair(16'h0005, 16'h0007);
    pair(16'h7fff, 16'h0001);
    pair(16'habcd, 16'h5432);

    load(1, 1, 16'h0f0f);   // R3 both strobes take the same word
    sweep();
    load(0, 0, 16'hdead);   // R2 R3 no strobe: operands hold
    sweep();

    @(negedge clk); #1;     // R10 mid-cycle address change
    src_addr = 5'(BASE + 1);
    #1 chk("R10 diff mid-cycle", int'(dut_out), 0);
    chk("R10 oe mid-cycle", int'(dut_oe), 1);
    src_addr = 5'(BASE + 2);
    #1 chk("R10 raw A mid-cycle", int'(dut_out), 16'h0f0f);
    src_addr = IDLE;
    #1 chk("R10 release mid-cycle", int'(dut_oe), 0);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule